// File: doc/BRIEF.md
# Event and Cycle Performance Counter

This block is a small memory-mapped performance monitor. It keeps one free-running cycle counter and two event counters. Each event counter takes its increments from one of a set of single-bit event inputs (cache misses, translation misses, pipeline stalls and similar pulses produced elsewhere in the chip). The input it follows is chosen by an 8-bit select field in a control register. Software reaches the four 32-bit registers through a plain register port: a write strobe, a 2-bit register index, write data, and read data that is combinational on the index.

Counting is gated in two ways. A debug-permission check stops the event counters when non-invasive debug is not allowed in the current mode, but the cycle counter keeps running. A validation-mode input freezes all three counters, so that another function can use them without interference. Each counter has an overflow flag that sets when the counter wraps. Each flag has its own interrupt enable. The interrupt output is the OR of all flags whose enable is set.

Top module: `perf_mon`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is low.
- R2: The register index selects the register as follows: 0 is control, 1 is the cycle counter, 2 is event counter 0, and 3 is event counter 1. The control register fields are: bit 0 global enable; bits 6:4 interrupt enables (bit 4 cycle, bit 5 event 0, bit 6 event 1); bits 10:8 overflow flags (bit 8 cycle, bit 9 event 0, bit 10 event 1); bits 23:16 select code for event counter 0; bits 31:24 select code for event counter 1. Bits 1, 2, 3, 7 and 15:11 read as 0.
- R3: While the enable bit is 1 and `validation_mode` is 0, the cycle counter increases by 1 on every clock, whatever the debug permission.
- R4: While counting is allowed, event counter n increases by 1 on each clock in which `evt_in[sel_n]` is 1.
- R5: Event counting is allowed only when `ext_dbg_en` is 1 and, in addition, either `priv_mode` or `user_dbg_en` is 1. When it is not allowed, both event counters hold their values.
- R6: While `validation_mode` is 1, all three counters hold their values.
- R7: A select code of NUM_EVT_SRC or above (8 or above by default) makes that event counter count nothing.
- R8: Writing the control register with bit 1 set clears both event counters. Writing it with bit 2 set clears the cycle counter.
- R9: A write to a counter register loads the written value into that counter. If the counter would also increment in that cycle, the write wins.
- R10: A counter wrapping from all ones to 0 sets its overflow flag. Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R11: `irq` is high whenever a set flag has its interrupt enable set, and stays high until such flags are cleared or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the indexed register |
| evt_in | input | NUM_EVT_SRC | Event pulses, one per source |
| ext_dbg_en | input | 1 | External non-invasive debug enable |
| user_dbg_en | input | 1 | Permits user-mode counting |
| priv_mode | input | 1 | Current mode is privileged |
| validation_mode | input | 1 | Counters are lent to another function |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench uses the default parameters: 32-bit counters and eight event sources. At this size every source can be swept against both counters, along with the out-of-range codes 8, 9 and 255. The wrap is reached by preloading values just below all ones rather than by counting up to them. The sweep also covers all eight combinations of the three permission inputs. Expected counts come from the window length and the bit of the event pattern that each counter selects.

// File: rtl/perf_mon_pkg.sv
// Shared constants for the performance monitor: register indices,
// control-register field positions and counter slot numbers.
package perf_mon_pkg;
    localparam int REG_W      = 32;
    localparam int SEL_W      = 8;
    localparam int NUM_SLOT   = 3;

    localparam int CTL_EN     = 0;
    localparam int CTL_EVRST  = 1;
    localparam int CTL_CYRST  = 2;
    localparam int CTL_IE_LSB = 4;
    localparam int CTL_OV_LSB = 8;
    localparam int CTL_S0_LSB = 16;
    localparam int CTL_S1_LSB = 24;

    localparam int SLOT_CYC   = 0;
    localparam int SLOT_EV0   = 1;
    localparam int SLOT_EV1   = 2;

    typedef enum logic [1:0] {
        IDX_CTRL = 2'd0,
        IDX_CYC  = 2'd1,
        IDX_EV0  = 2'd2,
        IDX_EV1  = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/perf_mon_evt_mux.sv
// Event selector: passes evt[sel] through when sel names an implemented
// source and returns 0 otherwise. Assumes NUM_SRC <= 2**SEL_W.
module perf_mon_evt_mux #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 8
) (
    input  logic [NUM_SRC-1:0] evt,
    input  logic [SEL_W-1:0]   sel,
    output logic               hit
);
    // Compare the code against every source index; unmatched codes give 0.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) hit = evt[i];
        end
    end
endmodule

// File: rtl/perf_mon_counter.sv
// One wrapping counter. Priority: load, then clear, then increment.
// wrap pulses in the cycle in which an accepted increment rolls over.
module perf_mon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ALL_ONES = '1;

    // Flag a roll-over only when the increment is not overridden.
    assign wrap = inc && !load && !clear && (cnt == ALL_ONES);

    // Update the count by priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (clear) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/perf_mon_ctrl.sv
// Control register: enable, interrupt enables, select codes and the
// overflow flags (set by wrap, cleared by writing 1). Also produces the
// one-cycle reset strobes and the interrupt. Reset bits are not stored.
module perf_mon_ctrl
    import perf_mon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [REG_W-1:0]    wdata,
    input  logic [NUM_SLOT-1:0] wrap,
    output logic                glob_en,
    output logic                evt_rst,
    output logic                cyc_rst,
    output logic [NUM_SLOT-1:0] irq_en,
    output logic [NUM_SLOT-1:0] ovf_flag,
    output logic [SEL_W-1:0]    sel0,
    output logic [SEL_W-1:0]    sel1,
    output logic [REG_W-1:0]    rd_val,
    output logic                irq
);
    logic [NUM_SLOT-1:0] clr_mask;

    assign evt_rst  = wr && wdata[CTL_EVRST];
    assign cyc_rst  = wr && wdata[CTL_CYRST];
    assign clr_mask = wr ? wdata[CTL_OV_LSB +: NUM_SLOT] : '0;

    // Store the configuration fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            irq_en  <= '0;
            sel0    <= '0;
            sel1    <= '0;
        end else if (wr) begin
            glob_en <= wdata[CTL_EN];
            irq_en  <= wdata[CTL_IE_LSB +: NUM_SLOT];
            sel0    <= wdata[CTL_S0_LSB +: SEL_W];
            sel1    <= wdata[CTL_S1_LSB +: SEL_W];
        end
    end

    // Overflow flags: a new wrap wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_flag <= '0;
        else        ovf_flag <= (ovf_flag & ~clr_mask) | wrap;
    end

    // Assemble the readable view of the register.
    always_comb begin
        rd_val                            = '0;
        rd_val[CTL_EN]                    = glob_en;
        rd_val[CTL_IE_LSB +: NUM_SLOT]    = irq_en;
        rd_val[CTL_OV_LSB +: NUM_SLOT]    = ovf_flag;
        rd_val[CTL_S0_LSB +: SEL_W]       = sel0;
        rd_val[CTL_S1_LSB +: SEL_W]       = sel1;
    end

    // The interrupt level follows the enabled flags.
    assign irq = |(ovf_flag & irq_en);
endmodule

// File: rtl/perf_mon.sv
// Performance monitor top: one cycle counter and two event counters with
// select multiplexers, permission gating, the validation-mode freeze and
// the register port. Assumes CNT_W <= 32 and NUM_EVT_SRC <= 256.
module perf_mon
    import perf_mon_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int NUM_EVT_SRC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [1:0]             reg_idx,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    input  logic [NUM_EVT_SRC-1:0] evt_in,
    input  logic                   ext_dbg_en,
    input  logic                   user_dbg_en,
    input  logic                   priv_mode,
    input  logic                   validation_mode,
    output logic                   irq
);
    localparam int NUM_EVT = NUM_SLOT - 1;

    logic                glob_en, evt_rst, cyc_rst, permit, run;
    logic [NUM_SLOT-1:0] irq_en, ovf_flag, wrap;
    logic [SEL_W-1:0]    sel [NUM_EVT];
    logic [REG_W-1:0]    ctrl_rd;
    logic [CNT_W-1:0]    cyc_q;
    logic [CNT_W-1:0]    evt_q [NUM_EVT];
    reg_idx_e            idx;

    assign idx    = reg_idx_e'(reg_idx);
    assign run    = glob_en && !validation_mode;
    assign permit = ext_dbg_en && (priv_mode || user_dbg_en);

    perf_mon_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr && idx == IDX_CTRL),
        .wdata    (reg_wdata),
        .wrap     (wrap),
        .glob_en  (glob_en),
        .evt_rst  (evt_rst),
        .cyc_rst  (cyc_rst),
        .irq_en   (irq_en),
        .ovf_flag (ovf_flag),
        .sel0     (sel[0]),
        .sel1     (sel[1]),
        .rd_val   (ctrl_rd),
        .irq      (irq)
    );

    perf_mon_counter #(.W(CNT_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reg_wr && idx == IDX_CYC),
        .load_val (reg_wdata[CNT_W-1:0]),
        .clear    (cyc_rst),
        .inc      (run),
        .cnt      (cyc_q),
        .wrap     (wrap[SLOT_CYC])
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        logic hit;

        perf_mon_evt_mux #(.NUM_SRC(NUM_EVT_SRC), .SEL_W(SEL_W)) u_mux (
            .evt (evt_in),
            .sel (sel[g]),
            .hit (hit)
        );

        perf_mon_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (reg_wr && reg_idx == 2'(IDX_EV0 + g)),
            .load_val (reg_wdata[CNT_W-1:0]),
            .clear    (evt_rst),
            .inc      (run && permit && hit),
            .cnt      (evt_q[g]),
            .wrap     (wrap[SLOT_EV0 + g])
        );
    end

    // Return the indexed register, counters zero-extended.
    always_comb begin
        unique case (idx)
            IDX_CTRL: reg_rdata = ctrl_rd;
            IDX_CYC:  reg_rdata = REG_W'(cyc_q);
            IDX_EV0:  reg_rdata = REG_W'(evt_q[0]);
            IDX_EV1:  reg_rdata = REG_W'(evt_q[1]);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/perf_mon_chk.sv
// Property checker for perf_mon, attached by bind below. Observes the
// ports plus the counter and control state of the top module.
module perf_mon_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_idx,
    input logic [31:0]      reg_wdata,
    input logic             ext_dbg_en,
    input logic             user_dbg_en,
    input logic             priv_mode,
    input logic             validation_mode,
    input logic             irq,
    input logic             glob_en,
    input logic [CNT_W-1:0] cyc_q,
    input logic [CNT_W-1:0] ev0_q,
    input logic [CNT_W-1:0] ev1_q,
    input logic [2:0]       ovf_flag
);
    logic allowed;
    assign allowed = ext_dbg_en && (priv_mode || user_dbg_en);

    AST_CYC_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && !validation_mode && !reg_wr) |=> cyc_q == $past(cyc_q) + 1'b1); // R3

    AST_EVT_HOLD_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!allowed && !reg_wr) |=> ($stable(ev0_q) && $stable(ev1_q))); // R5

    AST_FREEZE_VALIDATION: assert property (@(posedge clk) disable iff (!rst_n)
        (validation_mode && !reg_wr) |=> ($stable(cyc_q) && $stable(ev0_q) && $stable(ev1_q))); // R6

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == 2'd1) |=> cyc_q == $past(reg_wdata[CNT_W-1:0])); // R9

    AST_CYC_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && !validation_mode && !reg_wr && cyc_q == '1) |=> ovf_flag[0]); // R10

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr) |=> irq); // R11
endmodule

bind perf_mon perf_mon_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_wr          (reg_wr),
    .reg_idx         (reg_idx),
    .reg_wdata       (reg_wdata),
    .ext_dbg_en      (ext_dbg_en),
    .user_dbg_en     (user_dbg_en),
    .priv_mode       (priv_mode),
    .validation_mode (validation_mode),
    .irq             (irq),
    .glob_en         (glob_en),
    .cyc_q           (cyc_q),
    .ev0_q           (evt_q[0]),
    .ev1_q           (evt_q[1]),
    .ovf_flag        (ovf_flag)
);

// File: tb/perf_mon_tb.sv
// Self-checking bench for perf_mon with default parameters.
`timescale 1ns/1ps
module perf_mon_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_in = '0;
    logic        ext_dbg_en = 1'b1;
    logic        user_dbg_en = 1'b0;
    logic        priv_mode = 1'b1;
    logic        validation_mode = 1'b1;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    perf_mon u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .ext_dbg_en(ext_dbg_en), .user_dbg_en(user_dbg_en),
        .priv_mode(priv_mode), .validation_mode(validation_mode), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] v);
        reg_idx = idx;
        #0.5;
        v = reg_rdata;
    endtask

    // Open the counting gate for exactly n rising edges.
    task automatic window(input int n);
        @(negedge clk);
        validation_mode = 1'b0;
        repeat (n) @(negedge clk);
        validation_mode = 1'b1;
    endtask

    function automatic logic [31:0] ctl(input logic [7:0] s0, input logic [7:0] s1,
                                        input logic [2:0] ie, input logic [2:0] ov_clr,
                                        input logic rst_both);
        return {s1, s0, 5'd0, ov_clr, 1'b0, ie, 1'b0, rst_both, rst_both, 1'b1};
    endfunction

    function automatic int expect_evt(input int s, input logic [7:0] v, input int n);
        return (s < 8 && v[s]) ? n : 0;
    endfunction

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v);
            check("R1 reset value", v, 32'd0);
        end
        check("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R2: control field layout and readback; R9 counter preload
        wr(2'd0, 32'h1234_0777);
        rd(2'd0, v);
        check("R2 control readback", v, 32'h1234_0071);
        wr(2'd1, 32'hCAFE_0001);
        wr(2'd2, 32'h0BAD_0002);
        wr(2'd3, 32'h5EED_0003);
        rd(2'd1, v); check("R2 R9 cycle preload", v, 32'hCAFE_0001);
        rd(2'd2, v); check("R2 R9 event0 preload", v, 32'h0BAD_0002);
        rd(2'd3, v); check("R2 R9 event1 preload", v, 32'h5EED_0003);

        // R8: reset bits clear counters
        wr(2'd0, ctl(8'd0, 8'd0, 3'd0, 3'd0, 1'b1));
        for (int i = 1; i < 4; i++) begin
            rd(2'(i), v);
            check("R8 counter cleared", v, 32'd0);
        end

        // R3 R4 R7: sweep select codes and event patterns
        for (int k = 0; k < 11; k++) begin
            int s0 = (k < 10) ? k : 255;
            int s1 = s0 ^ 1;
            for (int p = 0; p < 3; p++) begin
                logic [7:0] pat;
                int n = 3 + p;
                pat = (p == 0) ? 8'(1 << s0) : (p == 1) ? ~8'(1 << s0) : 8'hFF;
                if (s0 >= 8 && p != 2) pat = (p == 0) ? 8'h00 : 8'hFF;
                wr(2'd0, ctl(8'(s0), 8'(s1), 3'd0, 3'd0, 1'b1));
                evt_in = pat;
                window(n);
                rd(2'd1, v); check("R3 cycle count", v, 32'(n));
                rd(2'd2, v); check("R4 R7 event0 count", v, 32'(expect_evt(s0, pat, n)));
                rd(2'd3, v); check("R4 R7 event1 count", v, 32'(expect_evt(s1, pat, n)));
            end
        end

        // R5: permission truth table
        for (int p = 0; p < 8; p++) begin
            logic ok;
            ext_dbg_en = p[0]; priv_mode = p[1]; user_dbg_en = p[2];
            ok = p[0] && (p[1] || p[2]);
            wr(2'd0, ctl(8'd2, 8'd5, 3'd0, 3'd0, 1'b1));
            evt_in = 8'hFF;
            window(6);
            rd(2'd1, v); check("R5 R3 cycle ignores permission", v, 32'd6);
            rd(2'd2, v); check("R5 event0 gated", v, ok ? 32'd6 : 32'd0);
            rd(2'd3, v); check("R5 event1 gated", v, ok ? 32'd6 : 32'd0);
        end
        ext_dbg_en = 1'b1; priv_mode = 1'b1; user_dbg_en = 1'b0;

        // R6: validation mode freezes everything
        wr(2'd0, ctl(8'd0, 8'd1, 3'd0, 3'd0, 1'b1));
        evt_in = 8'hFF;
        window(4);
        repeat (10) @(negedge clk);
        rd(2'd1, v); check("R6 cycle frozen", v, 32'd4);
        rd(2'd2, v); check("R6 event0 frozen", v, 32'd4);
        rd(2'd3, v); check("R6 event1 frozen", v, 32'd4);

        // R9: write beats a simultaneous increment
        wr(2'd0, ctl(8'd0, 8'd1, 3'd0, 3'd0, 1'b1));
        @(negedge clk);
        validation_mode = 1'b0; reg_wr = 1'b1; reg_idx = 2'd1; reg_wdata = 32'd100;
        @(negedge clk);
        reg_wr = 1'b0; validation_mode = 1'b1;
        rd(2'd1, v); check("R9 cycle write wins", v, 32'd100);
        rd(2'd2, v); check("R9 event0 still counted", v, 32'd1);
        @(negedge clk);
        validation_mode = 1'b0; reg_wr = 1'b1; reg_idx = 2'd2; reg_wdata = 32'd500;
        @(negedge clk);
        reg_wr = 1'b0; validation_mode = 1'b1;
        rd(2'd2, v); check("R9 event0 write wins", v, 32'd500);
        rd(2'd1, v); check("R9 cycle still counted", v, 32'd101);

        // R10 R11: overflow flags and interrupt
        wr(2'd0, ctl(8'd0, 8'd0, 3'b001, 3'd0, 1'b1));
        wr(2'd1, 32'hFFFF_FFFE);
        evt_in = 8'h00;
        window(3);
        rd(2'd1, v); check("R10 cycle wrapped", v, 32'd1);
        rd(2'd0, v); check("R10 cycle flag", v, 32'h0000_0111);
        check("R11 irq on cycle wrap", {31'd0, irq}, 32'd1);
        repeat (5) @(negedge clk);
        check("R11 irq held", {31'd0, irq}, 32'd1);
        wr(2'd2, 32'hFFFF_FFFF);
        evt_in = 8'h01;
        window(1);
        rd(2'd2, v); check("R10 event0 wrapped", v, 32'd0);
        rd(2'd0, v); check("R10 event0 flag", v, 32'h0000_0311);
        wr(2'd0, 32'h0000_0111);
        rd(2'd0, v); check("R10 clear one flag only", v, 32'h0000_0211);
        check("R11 masked flag no irq", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h0000_0031);
        check("R11 enable raises irq", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h0000_0231);
        rd(2'd0, v); check("R10 event0 flag cleared", v, 32'h0000_0031);
        check("R11 irq drops on clear", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h0000_0041);
        wr(2'd3, 32'hFFFF_FFFF);
        window(1);
        rd(2'd0, v); check("R10 event1 flag", v, 32'h0000_0441);
        check("R11 irq on event1 wrap", {31'd0, irq}, 32'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule